// File: doc/BRIEF.md
# Brute-Force Key Search Engine

This block is a single self-running key search engine for a known-plaintext attack. It holds a 64-bit known plaintext, a 64-bit target ciphertext and a 56-bit key counter. On every clock cycle of a run it sends the current key and the plaintext into a fixed-latency pipelined mixing cipher, and it advances the key by one. Each result that leaves the pipeline carries the key that produced it, and that result is compared against the target. When a result matches, the engine halts by itself and keeps the key that caused the match. When the loaded end key has been tried with no match, the engine halts with a separate exhausted flag.

A host sets up the engine through load strobes while it is idle, starts it, and then only polls it. The host may stop a run at any time. After a stop, the key value that can be read back is the oldest key whose result had not yet been compared. Restarting from that value therefore tries every key exactly once. Results still in the pipeline from before a start or a stop are marked invalid and are never compared.

Top module: `keysweep_unit`

## Requirements
- R1: After reset the engine is idle: `running`, `found` and `exhausted` are 0 and `cur_key` is 0.
- R2: While idle, each load strobe captures its data bus at the next clock edge (`ld_key` sets `cur_key`). While running, all four load strobes are ignored.
- R3: The cipher has STAGES rounds (default 4). Round s (0-based) maps x to rotl(x XOR spread(key), ROT) + (G + s), where ROT is 13, G is 64'h9E3779B97F4A7C15, bit i of spread(key) is key bit (i mod 56), and the addition is modulo 2^64. The ciphertext is the output of the last round, and round 0 takes the plaintext as its input.
- R4: During a run, one key enters per cycle, in ascending order modulo 2^56, starting at the loaded key. If the k-th key (k from 0) is the first that matches, `found` rises exactly k+STAGES+1 cycles after the clock edge that samples `start`.
- R5: On a match the engine halts, sets `found`, and shows the first matching key in search order on `cur_key`.
- R6: If no key from the start key through the end key (N keys) matches, the engine halts N+STAGES cycles after the start edge, with `exhausted` set and `cur_key` equal to the end key plus one.
- R7: When `stop` is sampled during a run, the engine is idle after that edge. `cur_key` then holds the oldest issued key whose result was not compared in that cycle, or the next key to issue if there is none. If the stop edge is j cycles after the start edge, this value is start+max(0, j-STAGES). Resuming from it finds the same matching key, with no key skipped.
- R8: A match in the same cycle as `stop` wins: `found` is set and the matching key is held. `found` and `exhausted` are never both 1.
- R9: `start` while idle clears both flags and discards every result still in flight. `start` while running has no effect on the run or its timing.
- R10: `running` is 1 from the edge after an accepted start until the edge at which the engine halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_plain | input | 1 | Capture `plain_in` as the known plaintext (idle only) |
| plain_in | input | BLK_W | Known plaintext data |
| ld_target | input | 1 | Capture `target_in` as the target ciphertext (idle only) |
| target_in | input | BLK_W | Target ciphertext data |
| ld_key | input | 1 | Capture `key_in` as the start or resume key (idle only) |
| key_in | input | KEY_W | Start key data |
| ld_end | input | 1 | Capture `end_in` as the last key to try (idle only) |
| end_in | input | KEY_W | End key data |
| start | input | 1 | Begin a run from `cur_key` |
| stop | input | 1 | Halt a run at a resumable key |
| running | output | 1 | Run in progress |
| found | output | 1 | Halted on a match |
| exhausted | output | 1 | Halted after the end key with no match |
| cur_key | output | KEY_W | Next untried key, or the matching key after a hit |

## Verification
Counted from the edge that samples `start`, a hit on key offset k is due at edge k+STAGES+1, and exhaustion of N keys at edge N+STAGES. The key held after a stop at edge j is start+max(0, j-STAGES). The bench drives every input on the falling edge. It counts falling edges from the first one after the start edge, so the count equals the edge number, and it compares that count exactly against the formula for each case. All expected keys and latencies come from a bench-side model of the round function, and that model scans the key range for the first match.

// File: rtl/keysweep_pkg.sv
package keysweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sweep_state_e;

    // Round constant seed; bit i of a round constant is seed bit (i mod 64)
    localparam logic [63:0] ROUND_SEED = 64'h9E3779B97F4A7C15;

endpackage

// File: rtl/keysweep_stage.sv
module keysweep_stage
    import keysweep_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int KEY_W = 56,
    parameter int ROT   = 13,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_v,
    input  logic [BLK_W-1:0] in_blk,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_v,
    output logic [BLK_W-1:0] out_blk,
    output logic [KEY_W-1:0] out_key
);

    typedef struct packed {
        logic             v;
        logic [BLK_W-1:0] blk;
        logic [KEY_W-1:0] key;
    } slot_t;

    slot_t q, d;
    logic [BLK_W-1:0] spread, rc, mixed, turned;

    always_comb begin
        for (int i = 0; i < BLK_W; i++) begin
            spread[i] = in_key[i % KEY_W];
            rc[i]     = ROUND_SEED[i % 64];
        end
        rc     = rc + BLK_W'(IDX);
        mixed  = in_blk ^ spread;
        turned = (mixed << ROT) | (mixed >> (BLK_W - ROT));
        d      = q;
        d.v    = in_v && !flush;
        d.blk  = turned + rc;
        d.key  = in_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_v   = q.v;
    assign out_blk = q.blk;
    assign out_key = q.key;

endmodule

// File: rtl/keysweep_pipe.sv
module keysweep_pipe #(
    parameter int BLK_W  = 64,
    parameter int KEY_W  = 56,
    parameter int STAGES = 4,
    parameter int ROT    = 13
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic                               in_v,
    input  logic [BLK_W-1:0]                   in_blk,
    input  logic [KEY_W-1:0]                   in_key,
    output logic                               out_v,
    output logic [BLK_W-1:0]                   out_blk,
    output logic [KEY_W-1:0]                   out_key,
    output logic [STAGES-2:0]                  tap_v,
    output logic [STAGES-2:0][KEY_W-1:0]       tap_key
);

    logic [STAGES:0]            v_w;
    logic [STAGES:0][BLK_W-1:0] blk_w;
    logic [STAGES:0][KEY_W-1:0] key_w;

    assign v_w[0]   = in_v;
    assign blk_w[0] = in_blk;
    assign key_w[0] = in_key;

    for (genvar s = 0; s < STAGES; s++) begin : g_round
        keysweep_stage #(
            .BLK_W(BLK_W), .KEY_W(KEY_W), .ROT(ROT), .IDX(s)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .in_v   (v_w[s]),
            .in_blk (blk_w[s]),
            .in_key (key_w[s]),
            .out_v  (v_w[s+1]),
            .out_blk(blk_w[s+1]),
            .out_key(key_w[s+1])
        );
    end

    // Taps on every stage except the last, for resume-point selection
    for (genvar t = 0; t < STAGES - 1; t++) begin : g_tap
        assign tap_v[t]   = v_w[t+1];
        assign tap_key[t] = key_w[t+1];
    end

    assign out_v   = v_w[STAGES];
    assign out_blk = blk_w[STAGES];
    assign out_key = key_w[STAGES];

endmodule

// File: rtl/keysweep_unit.sv
module keysweep_unit
    import keysweep_pkg::*;
#(
    parameter int KEY_W  = 56,
    parameter int BLK_W  = 64,
    parameter int STAGES = 4,
    parameter int ROT    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_plain,
    input  logic [BLK_W-1:0] plain_in,
    input  logic             ld_target,
    input  logic [BLK_W-1:0] target_in,
    input  logic             ld_key,
    input  logic [KEY_W-1:0] key_in,
    input  logic             ld_end,
    input  logic [KEY_W-1:0] end_in,
    input  logic             start,
    input  logic             stop,
    output logic             running,
    output logic             found,
    output logic             exhausted,
    output logic [KEY_W-1:0] cur_key
);

    typedef struct packed {
        sweep_state_e     st;
        logic [BLK_W-1:0] plain;
        logic [BLK_W-1:0] target;
        logic [KEY_W-1:0] ctr;
        logic [KEY_W-1:0] last;
        logic             hit;
        logic             empty;
    } ctl_t;

    ctl_t q, d;
    logic issue, flush, hit_now, oldest_hit;
    logic [KEY_W-1:0] oldest;

    logic                         pipe_out_v;
    logic [BLK_W-1:0]             pipe_out_blk;
    logic [KEY_W-1:0]             pipe_out_key;
    logic [STAGES-2:0]            tap_v;
    logic [STAGES-2:0][KEY_W-1:0] tap_key;

    keysweep_pipe #(
        .BLK_W(BLK_W), .KEY_W(KEY_W), .STAGES(STAGES), .ROT(ROT)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .in_v   (issue),
        .in_blk (q.plain),
        .in_key (q.ctr),
        .out_v  (pipe_out_v),
        .out_blk(pipe_out_blk),
        .out_key(pipe_out_key),
        .tap_v  (tap_v),
        .tap_key(tap_key)
    );

    // Oldest issued key not compared this cycle: deepest valid tap
    always_comb begin
        oldest     = q.ctr;
        oldest_hit = 1'b0;
        for (int i = 0; i < STAGES - 1; i++) begin
            if (tap_v[i]) begin
                oldest     = tap_key[i];
                oldest_hit = 1'b1;
            end
        end
    end

    always_comb begin
        d       = q;
        issue   = 1'b0;
        flush   = 1'b0;
        hit_now = pipe_out_v && (pipe_out_blk == q.target);
        case (q.st)
            ST_IDLE: begin
                if (ld_plain)  d.plain  = plain_in;
                if (ld_target) d.target = target_in;
                if (ld_key)    d.ctr    = key_in;
                if (ld_end)    d.last   = end_in;
                if (start) begin
                    d.st    = ST_RUN;
                    d.hit   = 1'b0;
                    d.empty = 1'b0;
                    flush   = 1'b1;
                end
            end
            ST_RUN, ST_DRAIN: begin
                if (hit_now) begin
                    d.st  = ST_IDLE;
                    d.hit = 1'b1;
                    d.ctr = pipe_out_key;
                    flush = 1'b1;
                end else if (stop) begin
                    d.st  = ST_IDLE;
                    d.ctr = oldest_hit ? oldest : q.ctr;
                    flush = 1'b1;
                end else if (q.st == ST_DRAIN) begin
                    if (pipe_out_v && pipe_out_key == q.last) begin
                        d.st    = ST_IDLE;
                        d.empty = 1'b1;
                        flush   = 1'b1;
                    end
                end else begin
                    issue = 1'b1;
                    d.ctr = q.ctr + KEY_W'(1);
                    if (q.ctr == q.last) d.st = ST_DRAIN;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign running   = (q.st != ST_IDLE);
    assign found     = q.hit;
    assign exhausted = q.empty;
    assign cur_key   = q.ctr;

endmodule

// File: rtl/keysweep_chk.sv
module keysweep_chk #(
    parameter int KEY_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop,
    input logic             ld_key,
    input logic             running,
    input logic             found,
    input logic             exhausted,
    input logic [KEY_W-1:0] cur_key,
    input logic             issue,
    input logic             flush,
    input logic             out_v
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && exhausted)) else $error("flags both set"); // R8

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop) |=> !running) else $error("stop ignored"); // R7

    AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && issue) |=> (cur_key == $past(cur_key) + KEY_W'(1)))
        else $error("key did not advance by one"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ld_key) |=> $stable(cur_key))
        else $error("idle key moved"); // R2

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (!found && !exhausted))
        else $error("flags not cleared on start"); // R9

    AST_FLUSH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_v) else $error("stale result kept"); // R9

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (found || exhausted || $past(stop)))
        else $error("halt without cause"); // R10

endmodule

bind keysweep_unit keysweep_chk #(.KEY_W(KEY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (stop),
    .ld_key   (ld_key),
    .running  (running),
    .found    (found),
    .exhausted(exhausted),
    .cur_key  (cur_key),
    .issue    (issue),
    .flush    (flush),
    .out_v    (pipe_out_v)
);

// File: tb/keysweep_unit_bench.sv
`timescale 1ns/1ps
module keysweep_unit_bench;

    localparam int KW = 56;
    localparam int BW = 64;
    localparam int S  = 4;
    localparam logic [63:0] SEED = 64'h9E3779B97F4A7C15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_plain = 0, ld_target = 0, ld_key = 0, ld_end = 0, start = 0, stop = 0;
    logic [BW-1:0] plain_in = '0, target_in = '0;
    logic [KW-1:0] key_in = '0, end_in = '0;
    logic running, found, exhausted;
    logic [KW-1:0] cur_key;

    int checks = 0;
    int fails  = 0;
    logic [63:0] pt = 64'h0123_4567_89AB_CDEF;

    always #2.5 clk = ~clk;

    keysweep_unit u_keysweep_unit (
        .clk(clk), .rst_n(rst_n),
        .ld_plain(ld_plain), .plain_in(plain_in),
        .ld_target(ld_target), .target_in(target_in),
        .ld_key(ld_key), .key_in(key_in),
        .ld_end(ld_end), .end_in(end_in),
        .start(start), .stop(stop),
        .running(running), .found(found), .exhausted(exhausted), .cur_key(cur_key)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of the round function stated in R3
    function automatic logic [63:0] cipher(input logic [63:0] p, input logic [55:0] k);
        logic [63:0] x, sp, m;
        x = p;
        for (int s = 0; s < S; s++) begin
            for (int i = 0; i < 64; i++) sp[i] = k[i % 56];
            m = x ^ sp;
            x = ((m << 13) | (m >> 51)) + (SEED + 64'(s));
        end
        return x;
    endfunction

    function automatic int first_hit(input logic [55:0] base, input int span, input logic [63:0] tgt);
        for (int i = 0; i < span; i++)
            if (cipher(pt, base + 56'(i)) == tgt) return i;
        return -1;
    endfunction

    task automatic load_all(input logic [63:0] tgt, input logic [55:0] k, input logic [55:0] e);
        @(negedge clk);
        ld_plain = 1; plain_in = pt; ld_target = 1; target_in = tgt;
        ld_key = 1; key_in = k; ld_end = 1; end_in = e;
        @(negedge clk);
        ld_plain = 0; ld_target = 0; ld_key = 0; ld_end = 0;
    endtask

    // Ends on the first falling edge after the edge that samples start
    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    // n enters as the edge count already reflected; leaves at the halt edge count
    task automatic wait_halt(inout int n);
        int lim;
        lim = n + 400;
        while (running && n < lim) begin
            @(negedge clk);
            n++;
        end
        if (running) chk(1'b0, "timeout", 64'(n), 64'(lim));
    endtask

    task automatic run_case(input logic [55:0] base, input logic [55:0] last, input logic [63:0] tgt);
        int span, idx, n;
        span = int'(last - base) + 1;
        idx  = first_hit(base, span, tgt);
        load_all(tgt, base, last);
        pulse_start();
        chk(running == 1'b1, "R10 running after start", 64'(running), 64'd1);
        n = 0;
        wait_halt(n);
        if (idx >= 0) begin
            chk(found == 1'b1, "R5 found", 64'(found), 64'd1);
            chk(exhausted == 1'b0, "R8 no exhaust on hit", 64'(exhausted), 64'd0);
            chk(cur_key == base + 56'(idx), "R3,R5 hit key", 64'(cur_key), 64'(base + 56'(idx)));
            chk(n == idx + S + 1, "R4 hit latency", 64'(n), 64'(idx + S + 1));
        end else begin
            chk(exhausted == 1'b1, "R6 exhausted", 64'(exhausted), 64'd1);
            chk(found == 1'b0, "R8 no hit", 64'(found), 64'd0);
            chk(cur_key == last + 56'd1, "R6 key after end", 64'(cur_key), 64'(last + 56'd1));
            chk(n == span + S, "R6 exhaust latency", 64'(n), 64'(span + S));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [55:0] bases [3];
        logic [55:0] b;
        int n, ck_off, rem;
        bases[0] = 56'd0;
        bases[1] = 56'hFF_FFFF_FFFF_FFF8;
        bases[2] = 56'h5A_C3E1_0F77_2B90;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(running == 1'b0,   "R1 running",   64'(running),   64'd0);
        chk(found == 1'b0,     "R1 found",     64'(found),     64'd0);
        chk(exhausted == 1'b0, "R1 exhausted", 64'(exhausted), 64'd0);
        chk(cur_key == '0,     "R1 cur_key",   64'(cur_key),   64'd0);
        rst_n = 1'b1;

        // Hit sweep over offsets, including a base that wraps (R3 R4 R5)
        for (int bi = 0; bi < 3; bi++)
            for (int k = 0; k < 16; k++)
                run_case(bases[bi], bases[bi] + 56'd40, cipher(pt, bases[bi] + 56'(k)));

        // Exhaust sweep over range lengths, wrapping through 2^56 (R6)
        for (int len = 1; len <= 8; len++)
            run_case(bases[1] + 56'd4, bases[1] + 56'd4 + 56'(len - 1), cipher(pt, 56'h77));

        // Hit on the end key itself (R5 R8)
        run_case(bases[2], bases[2] + 56'd6, cipher(pt, bases[2] + 56'd6));

        // Stop at edge j, then resume (R7)
        b = 56'h12_3456_789A_BC00;
        for (int j = 1; j <= 10; j++) begin
            load_all(cipher(pt, b + 56'd30), b, b + 56'd100);
            pulse_start();
            repeat (j - 1) @(negedge clk);
            stop = 1;
            @(negedge clk);
            stop = 0;
            ck_off = (j > S) ? j - S : 0;
            chk(running == 1'b0, "R7 halted by stop", 64'(running), 64'd0);
            chk(found == 1'b0, "R7 no flag on stop", 64'(found), 64'd0);
            chk(cur_key == b + 56'(ck_off), "R7 resume key", 64'(cur_key), 64'(b + 56'(ck_off)));
            rem = 30 - ck_off;
            pulse_start();
            n = 0;
            wait_halt(n);
            chk(found == 1'b1 && cur_key == b + 56'd30, "R7 resumed hit key", 64'(cur_key), 64'(b + 56'd30));
            chk(n == rem + S + 1, "R7 resumed latency", 64'(n), 64'(rem + S + 1));
        end

        // Stop in the very cycle the match is compared (R8)
        load_all(cipher(pt, b + 56'd5), b, b + 56'd20);
        pulse_start();
        repeat (5 + S) @(negedge clk);
        stop = 1;
        @(negedge clk);
        stop = 0;
        chk(found == 1'b1, "R8 match beats stop", 64'(found), 64'd1);
        chk(cur_key == b + 56'd5, "R8 match key kept", 64'(cur_key), 64'(b + 56'd5));

        // Loads during a run are ignored (R2)
        load_all(cipher(pt, b + 56'd20), b, b + 56'd50);
        pulse_start();
        ld_key = 1; key_in = 56'hAB; ld_target = 1; target_in = 64'hDEAD;
        ld_end = 1; end_in = b + 56'd2; ld_plain = 1; plain_in = ~pt;
        @(negedge clk);
        ld_key = 0; ld_target = 0; ld_end = 0; ld_plain = 0;
        n = 1;
        wait_halt(n);
        chk(found == 1'b1 && cur_key == b + 56'd20, "R2 run loads ignored", 64'(cur_key), 64'(b + 56'd20));
        chk(n == 20 + S + 1, "R2 run timing unchanged", 64'(n), 64'(20 + S + 1));

        // Idle key load is visible one edge later (R2)
        @(negedge clk); ld_key = 1; key_in = 56'h3C_0FF0_1234_5678;
        @(negedge clk); ld_key = 0;
        chk(cur_key == 56'h3C_0FF0_1234_5678, "R2 idle key load", 64'(cur_key), 64'h3C_0FF0_1234_5678);

        // Start while running has no effect (R9)
        load_all(cipher(pt, b + 56'd12), b, b + 56'd30);
        pulse_start();
        start = 1;
        @(negedge clk);
        start = 0;
        n = 1;
        wait_halt(n);
        chk(n == 12 + S + 1, "R9 start in run ignored", 64'(n), 64'(12 + S + 1));

        // Restart after a hit clears the flag and finds the held key at once (R9 R10)
        pulse_start();
        chk(found == 1'b0 && running == 1'b1, "R9 start clears found", 64'({found, running}), 64'b01);
        n = 0;
        wait_halt(n);
        chk(found == 1'b1 && cur_key == b + 56'd12, "R9 refind key", 64'(cur_key), 64'(b + 56'd12));
        chk(n == S + 1, "R10 refind latency", 64'(n), 64'(S + 1));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule